// File: doc/BRIEF.md
# Button-Driven Countdown Alarm Timer

This block is a small countdown timer steered by four single-cycle button pulses. After reset it sits stopped with the count loaded to 60. A start pulse makes it count down by one per clock cycle. When the count reaches zero, an alarm output rises and stays high until the user answers it.

A hold pulse freezes the count. An add pulse tops the count up by ten, limited to 60. A clear pulse returns the block to its loaded, stopped state from anywhere.

The buttons are expected to be already synchronised and shortened to one-cycle pulses, with at most one of them high in any cycle. The count advances on every clock edge, so a slower tick must be made by gating the clock domain upstream.

Top module: `countdown_alarm`

## Requirements
- R1: While rst_n is low, and after it is released, the block is stopped with count equal to 60 and alarm low.
- R2: While running, the count falls by exactly one each cycle without a button (or with start), and it never goes below 0.
- R3: The alarm and a count of 0 appear in the same cycle. The alarm then stays high, with the count held at 0, through idle cycles and through start and hold pulses.
- R4: A clear pulse in any state sets the count to 60, drops the alarm and stops counting.
- R5: A hold pulse while running freezes the count until a start pulse resumes the countdown (the first decrement comes one cycle after start) or a clear pulse arrives.
- R6: While held, an add pulse leaves the count unchanged.
- R7: An add pulse while stopped or running raises the count by 10, limited to 60, and keeps the current state. A running timer skips its decrement in that cycle.
- R8: An add pulse during the alarm sets the count to 10, drops the alarm and leaves the timer stopped until a start pulse.
- R9: While stopped, the count stays unchanged in cycles without a start, add or clear pulse; a hold pulse has no effect there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start or resume pulse |
| clear | input | 1 | Reload-and-stop pulse |
| hold | input | 1 | Freeze pulse |
| add | input | 1 | Add-ten pulse |
| alarm | output | 1 | High while the timer has expired and is unanswered |
| count | output | 6 | Current count, 60 down to 0 |

## Verification
The countdown is run over long stretches, so that a wrong step size or an early or late stop shows up as a drifting value. Add is tried at 60, at 25 and at 54. These three cases separate saturation from plain addition.

Add and start are applied during a hold, and start and hold are applied during the alarm. These cases show whether each state ignores the pulses it should ignore. Clear is applied from running, held, alarm and stopped states to prove that it wins from every state. Answering the alarm with add, and then starting again, checks the reload to 10 and a second expiry.

// File: rtl/countdown_alarm.sv
module countdown_alarm #(
  parameter int WIDTH = 6,
  parameter int LOAD  = 60,
  parameter int STEP  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic             hold,
  input  logic             add,
  output logic             alarm,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] LOADV = WIDTH'(LOAD);
  localparam logic [WIDTH:0]   LIMIT = (WIDTH+1)'(LOAD);

  typedef enum logic [1:0] {IDLE, RUN, PAUSE, RING} state_t;

  state_t           state, state_n;
  logic [WIDTH-1:0] count_n;
  logic             alarm_n;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] topped;

  assign sum    = {1'b0, count} + (WIDTH+1)'(STEP);
  assign topped = (sum > LIMIT) ? LOADV : sum[WIDTH-1:0];

  always_comb begin
    state_n = state;
    count_n = count;
    alarm_n = alarm;
    if (clear) begin
      state_n = IDLE;
      count_n = LOADV;
      alarm_n = 1'b0;
    end else begin
      unique case (state)
        IDLE: begin
          if (start) state_n = RUN;
          else if (add) count_n = topped;
        end
        RUN: begin
          if (hold) state_n = PAUSE;
          else if (add) count_n = topped;
          else if (count <= WIDTH'(1)) begin
            count_n = '0;
            state_n = RING;
            alarm_n = 1'b1;
          end else count_n = count - WIDTH'(1);
        end
        PAUSE: if (start) state_n = RUN;
        RING: begin
          if (add) begin
            count_n = WIDTH'(STEP);
            alarm_n = 1'b0;
            state_n = IDLE;
          end
        end
        default: state_n = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      count <= LOADV;
      alarm <= 1'b0;
    end else begin
      state <= state_n;
      count <= count_n;
      alarm <= alarm_n;
    end
  end

  a_r1_reset_load: assert property (@(posedge clk)
    $past(!rst_n) |-> (count == LOADV && !alarm));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && !clear && !hold && !add && count > WIDTH'(1)) |=> count == $past(count) - WIDTH'(1));

  a_r3_zero_with_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> count == '0);

  a_r3_alarm_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !add && !clear) |=> alarm);

  a_r4_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == LOADV && !alarm));

  a_r6_add_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PAUSE && add) |=> $stable(count));

  a_r7_add_limit: assert property (@(posedge clk) disable iff (!rst_n)
    add |=> count <= LOADV);

  a_r8_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && add) |=> (!alarm && count == WIDTH'(STEP)));

endmodule

// File: tb/countdown_alarm_test.sv
module countdown_alarm_test;
  logic clk = 0, rst_n = 0, start = 0, clear = 0, hold = 0, add = 0;
  logic alarm;
  logic [5:0] count;

  countdown_alarm uut (.clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
                       .hold(hold), .add(add), .alarm(alarm), .count(count));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  // reference model from the requirements: 0 idle, 1 run, 2 held, 3 alarm
  int m_st = 0;
  int m_cnt = 60;
  bit m_al = 0;

  // b: 0 none, 1 start, 2 clear, 3 hold, 4 add
  task automatic step(input int b, input string tag);
    @(negedge clk);
    start = (b == 1); clear = (b == 2); hold = (b == 3); add = (b == 4);
    if (b == 2) begin m_cnt = 60; m_st = 0; m_al = 0; end
    else case (m_st)
      0: if (b == 1) m_st = 1; else if (b == 4) m_cnt = (m_cnt + 10 > 60) ? 60 : m_cnt + 10;
      1: if (b == 3) m_st = 2;
         else if (b == 4) m_cnt = (m_cnt + 10 > 60) ? 60 : m_cnt + 10;
         else if (m_cnt <= 1) begin m_cnt = 0; m_st = 3; m_al = 1; end
         else m_cnt = m_cnt - 1;
      2: if (b == 1) m_st = 1;
      default: if (b == 4) begin m_cnt = 10; m_al = 0; m_st = 0; end
    endcase
    exp_q.push_back({m_al, 6'(m_cnt)});
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({alarm, count} !== e) begin
          fails++;
          $display("FAIL %s: alarm=%0b count=%0d, expected alarm=%0b count=%0d",
                   t, alarm, count, e[6], e[5:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (count !== 6'd60 || alarm !== 1'b0) begin
      fails++;
      $display("FAIL R1: alarm=%0b count=%0d, expected alarm=0 count=60", alarm, count);
    end
    rst_n = 1;
    step(0, "R1");
    run(2, "R9");
    step(3, "R9");                 // hold while stopped: no effect
    step(4, "R7");                 // 60 saturates
    step(1, "R2");
    run(35, "R2");                 // 60 -> 25
    step(4, "R7");                 // 25 -> 35
    run(2, "R2");
    step(3, "R5");
    run(3, "R5");
    step(4, "R6");
    step(1, "R5");
    run(2, "R5");
    run(40, "R3");                 // reaches 0, alarm
    step(1, "R3");
    step(3, "R3");
    run(2, "R3");
    step(4, "R8");                 // answer: 10, stopped
    run(3, "R8");
    step(1, "R8");
    run(12, "R3");                 // second expiry
    step(2, "R4");                 // clear from alarm
    step(1, "R4");
    run(6, "R2");                  // 60 -> 54
    step(4, "R7");                 // 54 -> 60
    run(3, "R2");
    step(2, "R4");                 // clear while running
    run(2, "R9");
    step(1, "R5");
    step(3, "R5");
    step(2, "R4");                 // clear while held
    step(2, "R4");                 // clear while stopped
    run(2, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule